// File: doc/BRIEF.md
# Instruction Field Decoder with Branch Condition Flag

This block sits next to the instruction register of a single-bus load/store processor. It splits the instruction word into its parts. It passes the opcode through. It picks one of three 4-bit register fields and turns it into a one-hot line for each of the sixteen general registers. It also widens the 18-bit constant field to a full 32-bit word, copying the sign bit.

The one-hot line is used in two ways. A register-in strobe from the sequencer makes it a write enable. A register-out strobe makes it a bus-drive select, so at most one register places data on the shared bus. When register 0 is chosen as a driver and the base-address strobe is low, the block raises a separate line that tells register 0 to drive zero. An Rb field of zero then gives pure constant addressing.

A condition unit compares the value on the bus against a 2-bit condition code taken from the instruction. It loads a branch flag only when the sequencer pulses the condition-load strobe. When the flag is set, the sequencer forms the branch target as PC + 1 + C.

Top module: `irDecodeBranch`

## Requirements
- R1: `opcode` always equals instruction bits [31:27].
- R2: `selRa` chooses field bits [26:23], `selRb` chooses bits [22:19] and `selRc` chooses bits [18:15]. When several selects are high, Ra wins over Rb and Rb wins over Rc. With no select high, no register line is active.
- R3: The chosen 4-bit field value N activates only bit N of the 16-line decode.
- R4: `regWriteEn` carries the decoded line while `regInStb` is high and is all zero while `regInStb` is low.
- R5: `regDriveSel` carries the decoded line while `regOutStb` is high and is all zero while it is low. It never has more than one bit set.
- R6: `r0ZeroDrive` is high exactly when bit 0 of `regDriveSel` is high and `baseOutStb` is low.
- R7: `immExt` is instruction bits [17:0] with bit 17 copied into bits [31:18].
- R8: The condition code is instruction bits [20:19]. Code 00 means the bus is zero. Code 01 means the bus is nonzero. Code 10 means the bus is positive (bit 31 clear and the value nonzero). Code 11 means the bus is negative (bit 31 set).
- R9: At a rising clock edge with `condLoadStb` high, `branchFlag` takes the result of the condition test. At any edge with `condLoadStb` low, `branchFlag` keeps its value.
- R10: While `rstN` is low, `branchFlag` is cleared at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the branch flag |
| rstN | input | 1 | Asynchronous reset, active low |
| irWord | input | 32 | Instruction register contents |
| busValue | input | 32 | Value on the shared bus, tested by the condition unit |
| selRa | input | 1 | Select the Ra field for decoding |
| selRb | input | 1 | Select the Rb field for decoding |
| selRc | input | 1 | Select the Rc field for decoding |
| regInStb | input | 1 | Make the decoded line a register write enable |
| regOutStb | input | 1 | Make the decoded line a bus-drive select |
| baseOutStb | input | 1 | Let register 0 drive its real contents |
| condLoadStb | input | 1 | Load the branch flag at the next edge |
| opcode | output | 5 | Opcode field |
| regWriteEn | output | 16 | Per-register write enables |
| regDriveSel | output | 16 | Per-register bus-drive selects |
| r0ZeroDrive | output | 1 | Register 0 must drive zero onto the bus |
| immExt | output | 32 | Sign-extended constant |
| branchFlag | output | 1 | Latched branch decision |

## Verification
On every cycle the assertions check these properties:
- at most one bus driver is selected;
- write enables and drive selects agree whenever both strobes are high;
- the zero-drive line only appears together with a register 0 drive select;
- the upper bits of the extended constant all match its sign;
- the branch flag holds while no load strobe is given;
- a zero bus under code 00, and a non-negative bus under code 11, set and clear the flag as they should.

Only the bench scenarios can show the rest:
- that each field lands on the correct line number;
- that the select priority works;
- that each of the four condition codes is right at the positive and negative boundaries;
- that the asynchronous reset clears a set flag.

// File: rtl/irDecodePkg.sv
package irDecodePkg;

  typedef enum logic [1:0] {
    CC_ZERO    = 2'b00,
    CC_NONZERO = 2'b01,
    CC_POS     = 2'b10,
    CC_NEG     = 2'b11
  } condCode_e;

  typedef struct packed {
    logic selA;
    logic selB;
    logic selC;
    logic regIn;
    logic regOut;
    logic baseOut;
    logic condLoad;
  } ctrlStrobes_t;

endpackage

// File: rtl/regSelectDecode.sv
module regSelectDecode
  import irDecodePkg::*;
#(
  parameter int IR_W  = 32,
  parameter int OPC_W = 5,
  parameter int REG_W = 4
) (
  input  logic [IR_W-1:0]          irWord,
  input  ctrlStrobes_t             strobes,
  output logic [OPC_W-1:0]         opcode,
  output logic [(1<<REG_W)-1:0]    regWriteEn,
  output logic [(1<<REG_W)-1:0]    regDriveSel,
  output logic                     r0ZeroDrive
);

  localparam int NUM_REGS = 1 << REG_W;
  localparam int OPC_LSB  = IR_W - OPC_W;
  localparam int RA_LSB   = OPC_LSB - REG_W;
  localparam int RB_LSB   = RA_LSB - REG_W;
  localparam int RC_LSB   = RB_LSB - REG_W;

  logic [REG_W-1:0]    fieldVal;
  logic                anySel;
  logic [NUM_REGS-1:0] decoded;

  assign opcode = irWord[IR_W-1:OPC_LSB];

  // Field pick with fixed priority Ra > Rb > Rc
  always_comb begin
    fieldVal = '0;
    anySel   = 1'b1;
    if (strobes.selA)      fieldVal = irWord[RA_LSB +: REG_W];
    else if (strobes.selB) fieldVal = irWord[RB_LSB +: REG_W];
    else if (strobes.selC) fieldVal = irWord[RC_LSB +: REG_W];
    else                   anySel   = 1'b0;
  end

  // One-hot decode, one comparator per register line
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_line
    assign decoded[i] = anySel && (fieldVal == REG_W'(i));
  end

  assign regWriteEn  = strobes.regIn  ? decoded : '0;
  assign regDriveSel = strobes.regOut ? decoded : '0;
  assign r0ZeroDrive = regDriveSel[0] && !strobes.baseOut;

  always_comb begin
    // R5
    single_drive_chk: assert ($onehot0(regDriveSel));
    // R4
    in_out_agree_chk: assert (!(strobes.regIn && strobes.regOut) || (regWriteEn == regDriveSel));
    // R6
    r0_zero_src_chk: assert (!r0ZeroDrive || regDriveSel[0]);
  end

endmodule

// File: rtl/immCondPath.sv
module immCondPath
  import irDecodePkg::*;
#(
  parameter int IR_W   = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 18,
  parameter int CC_LSB = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IR_W-1:0]   irWord,
  input  logic [DATA_W-1:0] busValue,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] immExt,
  output logic              branchFlag
);

  localparam int EXT_W = DATA_W - IMM_W;

  condCode_e condCode;
  logic      busZero;
  logic      busNeg;
  logic      condMet;

  assign immExt = {{EXT_W{irWord[IMM_W-1]}}, irWord[IMM_W-1:0]};

  assign condCode = condCode_e'(irWord[CC_LSB +: 2]);
  assign busZero  = (busValue == '0);
  assign busNeg   = busValue[DATA_W-1];

  always_comb begin
    unique case (condCode)
      CC_ZERO:    condMet = busZero;
      CC_NONZERO: condMet = !busZero;
      CC_POS:     condMet = !busNeg && !busZero;
      CC_NEG:     condMet = busNeg;
      default:    condMet = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 branchFlag <= 1'b0;
    else if (strobes.condLoad) branchFlag <= condMet;
  end

  always_comb begin
    // R7
    sign_ext_chk: assert (($countones(immExt[DATA_W-1:IMM_W-1]) == 0) ||
                          ($countones(immExt[DATA_W-1:IMM_W-1]) == EXT_W + 1));
  end

  // R9
  hold_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.condLoad |=> $stable(branchFlag));

  // R8
  zero_branch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.condLoad && irWord[CC_LSB +: 2] == 2'b00 && busValue == '0) |=> branchFlag);

  // R8
  neg_branch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.condLoad && irWord[CC_LSB +: 2] == 2'b11 && !busValue[DATA_W-1]) |=> !branchFlag);

endmodule

// File: rtl/irDecodeBranch.sv
module irDecodeBranch
  import irDecodePkg::*;
#(
  parameter int IR_W   = 32,
  parameter int DATA_W = 32,
  parameter int OPC_W  = 5,
  parameter int REG_W  = 4,
  parameter int IMM_W  = 18,
  parameter int CC_LSB = 19
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IR_W-1:0]       irWord,
  input  logic [DATA_W-1:0]     busValue,
  input  logic                  selRa,
  input  logic                  selRb,
  input  logic                  selRc,
  input  logic                  regInStb,
  input  logic                  regOutStb,
  input  logic                  baseOutStb,
  input  logic                  condLoadStb,
  output logic [OPC_W-1:0]      opcode,
  output logic [(1<<REG_W)-1:0] regWriteEn,
  output logic [(1<<REG_W)-1:0] regDriveSel,
  output logic                  r0ZeroDrive,
  output logic [DATA_W-1:0]     immExt,
  output logic                  branchFlag
);

  ctrlStrobes_t strobes;

  assign strobes = '{selA: selRa, selB: selRb, selC: selRc,
                     regIn: regInStb, regOut: regOutStb,
                     baseOut: baseOutStb, condLoad: condLoadStb};

  regSelectDecode #(.IR_W(IR_W), .OPC_W(OPC_W), .REG_W(REG_W)) uDecode (
    .irWord      (irWord),
    .strobes     (strobes),
    .opcode      (opcode),
    .regWriteEn  (regWriteEn),
    .regDriveSel (regDriveSel),
    .r0ZeroDrive (r0ZeroDrive)
  );

  immCondPath #(.IR_W(IR_W), .DATA_W(DATA_W), .IMM_W(IMM_W), .CC_LSB(CC_LSB)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .irWord     (irWord),
    .busValue   (busValue),
    .strobes    (strobes),
    .immExt     (immExt),
    .branchFlag (branchFlag)
  );

endmodule

// File: tb/irDecodeBranch_test.sv
module irDecodeBranch_test;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC    = 8;

  localparam logic [31:0] IR_A = {5'd3,  4'd7, 4'd2,  4'd12, 15'h0000};
  localparam logic [31:0] IR_B = {5'd31, 4'd0, 4'd15, 4'd0,  15'h7FFF};

  // {ir, sel{a,b,c}, regIn, regOut, valid, idx}
  localparam logic [41:0] VECS [NUM_VEC] = '{
    {IR_A, 3'b100, 1'b1, 1'b0, 1'b1, 4'd7},
    {IR_A, 3'b010, 1'b0, 1'b1, 1'b1, 4'd2},
    {IR_A, 3'b001, 1'b1, 1'b1, 1'b1, 4'd12},
    {IR_A, 3'b110, 1'b1, 1'b1, 1'b1, 4'd7},
    {IR_A, 3'b011, 1'b1, 1'b0, 1'b1, 4'd2},
    {IR_A, 3'b000, 1'b1, 1'b1, 1'b0, 4'd0},
    {IR_B, 3'b100, 1'b0, 1'b1, 1'b1, 4'd0},
    {IR_B, 3'b010, 1'b1, 1'b1, 1'b1, 4'd15}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irWord = '0;
  logic [31:0] busValue = '0;
  logic        selRa = 1'b0, selRb = 1'b0, selRc = 1'b0;
  logic        regInStb = 1'b0, regOutStb = 1'b0, baseOutStb = 1'b0, condLoadStb = 1'b0;
  logic [4:0]  opcode;
  logic [15:0] regWriteEn, regDriveSel;
  logic        r0ZeroDrive;
  logic [31:0] immExt;
  logic        branchFlag;

  int checkCount = 0;
  int failCount  = 0;
  logic [41:0] v;
  logic [15:0] expWr, expDr;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irDecodeBranch uut (
    .clk(clk), .rstN(rstN), .irWord(irWord), .busValue(busValue),
    .selRa(selRa), .selRb(selRb), .selRc(selRc),
    .regInStb(regInStb), .regOutStb(regOutStb), .baseOutStb(baseOutStb),
    .condLoadStb(condLoadStb),
    .opcode(opcode), .regWriteEn(regWriteEn), .regDriveSel(regDriveSel),
    .r0ZeroDrive(r0ZeroDrive), .immExt(immExt), .branchFlag(branchFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic condCase(input logic [1:0] cc, input logic [31:0] bus, input logic exp, input string req);
    @(negedge clk);
    irWord      = {11'd0, cc, 19'd0};
    busValue    = bus;
    condLoadStb = 1'b1;
    @(negedge clk);
    condLoadStb = 1'b0;
    check(req, {31'd0, branchFlag}, {31'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failCount++;
      checkCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    #1;
    check("R10 reset flag", {31'd0, branchFlag}, 32'd0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // Table-driven decode: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NUM_VEC; i++) begin
      @(negedge clk);
      v = VECS[i];
      irWord = v[41:10];
      {selRa, selRb, selRc} = v[9:7];
      regInStb  = v[6];
      regOutStb = v[5];
      baseOutStb = 1'b0;
      #1;
      expWr = (v[4] && v[6]) ? (16'd1 << v[3:0]) : 16'd0;
      expDr = (v[4] && v[5]) ? (16'd1 << v[3:0]) : 16'd0;
      check("R1 opcode", {27'd0, opcode}, {27'd0, v[41:37]});
      check("R2/R3/R4 write enable", {16'd0, regWriteEn}, {16'd0, expWr});
      check("R2/R3/R5 drive select", {16'd0, regDriveSel}, {16'd0, expDr});
      check("R6 zero drive", {31'd0, r0ZeroDrive}, {31'd0, expDr[0]});
    end

    // R6: base-address strobe lets R0 drive its contents
    @(negedge clk);
    irWord = IR_B; {selRa, selRb, selRc} = 3'b100; regOutStb = 1'b1; baseOutStb = 1'b1;
    #1;
    check("R6 base out suppresses zero", {31'd0, r0ZeroDrive}, 32'd0);
    regOutStb = 1'b0; baseOutStb = 1'b0; regInStb = 1'b0; {selRa, selRb, selRc} = 3'b000;

    // R7 sign extension
    irWord = 32'h0002_0000; #1;
    check("R7 negative constant", immExt, 32'hFFFE_0000);
    irWord = 32'hFFFD_FFFF; #1;
    check("R7 positive constant", immExt, 32'h0001_FFFF);
    irWord = 32'h0000_0000; #1;
    check("R7 zero constant", immExt, 32'h0000_0000);

    // R8 condition codes
    condCase(2'b00, 32'd0,         1'b1, "R8 zero on zero");
    condCase(2'b00, 32'd5,         1'b0, "R8 zero on nonzero");
    condCase(2'b01, 32'd5,         1'b1, "R8 nonzero on nonzero");
    condCase(2'b01, 32'd0,         1'b0, "R8 nonzero on zero");
    condCase(2'b10, 32'd1,         1'b1, "R8 positive on one");
    condCase(2'b10, 32'h8000_0000, 1'b0, "R8 positive on negative");
    condCase(2'b10, 32'd0,         1'b0, "R8 positive on zero");
    condCase(2'b11, 32'h8000_0000, 1'b1, "R8 negative on min");
    condCase(2'b11, 32'd1,         1'b0, "R8 negative on positive");

    // R9 hold without strobe
    condCase(2'b11, 32'hFFFF_FFFF, 1'b1, "R9 set before hold");
    @(negedge clk);
    irWord = 32'd0; busValue = 32'd7;
    @(negedge clk);
    check("R9 hold without strobe", {31'd0, branchFlag}, 32'd1);

    // R10 asynchronous reset mid-cycle
    #1 rstN = 1'b0;
    #1;
    check("R10 async clear", {31'd0, branchFlag}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule